// File: doc/BRIEF.md
# Integer-Factor Sample-Rate Reducer

This block cuts the sample rate of a data stream by a fixed integer factor M in a design where everything runs on one clock and the rates are set by clock enables. Input samples are marked by an input-rate strobe (`in_ce`), which may be high every cycle or only on some cycles. The block groups every M marked samples into a frame, keeps one sample per frame and discards the rest. It raises an output-rate strobe (`out_ce`) once per frame. Logic downstream runs on that strobe.

A parameter picks one of three build variants:
- **Last-of-frame with latency.** This is the cheapest. One register captures the final sample of the frame.
- **First-of-frame with latency.** This adds one register that holds the opening sample until the frame closes.
- **First-of-frame with zero latency.** The kept sample reaches the output in the same cycle through a multiplexer. A registered shutter flag steers the multiplexer. The cost is a combinational path from `din` to `dout`, which must be budgeted in timing as a hazard.

Filtering before decimation and the generation of the enables are left to surrounding logic.

Top module: `dsr_decim`

## Requirements
- R1: Of every M consecutive cycles with `in_ce` high, exactly one has `out_ce` high, and `out_ce` is never high when `in_ce` is low.
- R2: The frame position runs 0..M-1 and advances only on `in_ce`, wrapping to 0 after M-1. In the latency variants (`KEEP_LAST`=1, `KEEP_FIRST`=2), `out_ce` fires with the sample at position M-1. In the zero-latency variant (`KEEP_ZERO_LAT`=0), it fires with the sample at position 0.
- R3: In `KEEP_LAST`, `dout` takes the value of `din` from the `out_ce` cycle at the next rising clock edge.
- R4: In `KEEP_FIRST`, `dout` takes, at the rising edge that closes the `out_ce` cycle, the `din` value that came with the position-0 sample of the same frame.
- R5: In `KEEP_ZERO_LAT`, during an `out_ce` cycle `dout` equals the current `din` in that same cycle.
- R6: Outside update cycles, `dout` keeps its last kept value. `din` changes while `in_ce` is low affect neither `dout` nor the frame position.
- R7: While `rst_n` is low, the position counter and all data registers are zero. With `in_ce` low, `dout` reads 0 and `out_ce` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_ce | input | 1 | Input-rate enable; marks a valid `din` sample |
| din | input | DW | Input sample |
| out_ce | output | 1 | Output-rate enable, one pulse per frame |
| dout | output | DW | Kept sample, held between updates |

## Verification
The bench builds three copies side by side from one stimulus stream. The zero-latency variant uses M=3, last-of-frame uses M=4 and first-of-frame uses M=5. Because the three factors are unequal and coprime, the frame boundaries of the copies drift against each other, so every wrap position meets every mix of `in_ce` gaps. Stretches with `in_ce` high every cycle, random `in_ce` density, long idle stretches with `din` toggling, and a reset in mid-frame show that each variant keeps the right sample and holds it.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef enum logic [1:0] {
    KEEP_ZERO_LAT = 2'd0,
    KEEP_LAST     = 2'd1,
    KEEP_FIRST    = 2'd2
  } keep_mode_e;

  // position that follows pos in a frame of m samples
  function automatic int unsigned pos_after(input int unsigned pos, input int unsigned m);
    return (pos + 1 == m) ? 0 : pos + 1;
  endfunction

  // frame position whose sample produces the output strobe
  function automatic int unsigned strobe_pos(input keep_mode_e mode, input int unsigned m);
    return (mode == KEEP_ZERO_LAT) ? 0 : m - 1;
  endfunction

endpackage

// File: rtl/dsr_frame_ctr.sv
module dsr_frame_ctr #(
  parameter int unsigned        M    = 4,
  parameter dsr_pkg::keep_mode_e MODE = dsr_pkg::KEEP_LAST,
  localparam int unsigned       CW   = (M > 2) ? $clog2(M) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_ce,
  output logic [CW-1:0] pos,
  output logic          cap_ce,
  output logic          upd_ce
);
  import dsr_pkg::*;

  localparam int unsigned UPD_POS = strobe_pos(MODE, M);

  logic [CW-1:0] pos_q, pos_n;
  logic          at_first_q;   // registered shutter: next sample opens a frame
  logic          at_last_q;    // next sample closes a frame

  always_comb pos_n = CW'(pos_after(int'(pos_q), M));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q      <= '0;
      at_first_q <= 1'b1;
      at_last_q  <= 1'b0;
    end else if (in_ce) begin
      pos_q      <= pos_n;
      at_first_q <= (pos_n == '0);
      at_last_q  <= (pos_n == CW'(M - 1));
    end
  end

  assign pos    = pos_q;
  assign cap_ce = in_ce & ((MODE == KEEP_LAST) ? at_last_q : at_first_q);
  assign upd_ce = in_ce & ((UPD_POS == 0) ? at_first_q : at_last_q);

endmodule

// File: rtl/dsr_keep_path.sv
module dsr_keep_path #(
  parameter int unsigned        DW   = 8,
  parameter dsr_pkg::keep_mode_e MODE = dsr_pkg::KEEP_LAST
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_ce,
  input  logic          upd_ce,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [DW-1:0] first_hold
);
  import dsr_pkg::*;

  generate
    if (MODE == KEEP_ZERO_LAT) begin : g_zero
      logic [DW-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold_q <= '0;
        else if (cap_ce) hold_q <= din;
      end
      // shutter mux: live input passes straight to dout (timing hazard)
      assign dout       = upd_ce ? din : hold_q;
      assign first_hold = '0;
    end else if (MODE == KEEP_LAST) begin : g_last
      logic [DW-1:0] out_q;
      // capture and update strobes coincide in this variant
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               out_q <= '0;
        else if (cap_ce & upd_ce) out_q <= din;
      end
      assign dout       = out_q;
      assign first_hold = '0;
    end else begin : g_first
      logic [DW-1:0] open_q, out_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          open_q <= '0;
          out_q  <= '0;
        end else begin
          if (cap_ce) open_q <= din;
          if (upd_ce) out_q  <= open_q;
        end
      end
      assign dout       = out_q;
      assign first_hold = open_q;
    end
  endgenerate

endmodule

// File: rtl/dsr_decim.sv
module dsr_decim #(
  parameter int unsigned        DW   = 16,
  parameter int unsigned        M    = 4,
  parameter dsr_pkg::keep_mode_e MODE = dsr_pkg::KEEP_LAST
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_ce,
  input  logic [DW-1:0] din,
  output logic          out_ce,
  output logic [DW-1:0] dout
);
  localparam int unsigned CW = (M > 2) ? $clog2(M) : 1;

  generate
    if (M < 2) begin : g_bad_m
      initial $error("dsr_decim: M must be at least 2");
    end
  endgenerate

  logic [CW-1:0] frame_pos;
  logic          cap_ce;
  logic          upd_ce;
  logic [DW-1:0] first_hold;

  dsr_frame_ctr #(.M(M), .MODE(MODE)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_ce  (in_ce),
    .pos    (frame_pos),
    .cap_ce (cap_ce),
    .upd_ce (upd_ce)
  );

  dsr_keep_path #(.DW(DW), .MODE(MODE)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_ce     (cap_ce),
    .upd_ce     (upd_ce),
    .din        (din),
    .dout       (dout),
    .first_hold (first_hold)
  );

  assign out_ce = upd_ce;

endmodule

// File: rtl/dsr_decim_chk.sv
module dsr_decim_chk #(
  parameter int unsigned        DW   = 16,
  parameter int unsigned        M    = 4,
  parameter dsr_pkg::keep_mode_e MODE = dsr_pkg::KEEP_LAST,
  localparam int unsigned       CW   = (M > 2) ? $clog2(M) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ce,
  input logic [DW-1:0] din,
  input logic          out_ce,
  input logic [DW-1:0] dout,
  input logic [CW-1:0] frame_pos,
  input logic [DW-1:0] first_hold
);
  import dsr_pkg::*;

  // independent count of input samples since the last kept one
  int unsigned gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gap <= (MODE == KEEP_ZERO_LAT) ? M - 1 : 0;
    else if (in_ce) gap <= (gap == M - 1) ? 0 : gap + 1;
  end

  // R1
  keep_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ce && gap == M - 1) |-> out_ce);
  // R1
  keep_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ce |-> (in_ce && gap == M - 1));
  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(frame_pos) < M);
  // R2
  pos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ce |=> $stable(frame_pos));

  generate
    if (MODE == KEEP_LAST) begin : g_last
      // R3
      last_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ce |=> dout == $past(din));
    end else if (MODE == KEEP_FIRST) begin : g_first
      // R4
      first_grab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ce && gap == 0) |=> first_hold == $past(din));
      // R4
      first_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ce |=> dout == $past(first_hold));
    end else begin : g_zero
      // R5
      zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ce |-> dout == din);
      // R6
      zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_ce && !$past(out_ce)) |-> $stable(dout));
    end
    if (MODE != KEEP_ZERO_LAT) begin : g_lat_hold
      // R6
      lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ce |=> $stable(dout));
    end
  endgenerate

endmodule

bind dsr_decim dsr_decim_chk #(.DW(DW), .M(M), .MODE(MODE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ce      (in_ce),
  .din        (din),
  .out_ce     (out_ce),
  .dout       (dout),
  .frame_pos  (frame_pos),
  .first_hold (first_hold)
);

// File: tb/dsr_decim_tb.sv
module dsr_decim_tb;
  localparam int unsigned DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_ce = 1'b0;
  logic [DW-1:0] din = '0;
  logic          dst_w  [3];
  logic [DW-1:0] dout_w [3];

  always #4 clk = ~clk;

  // variant 0: zero latency, M=3; 1: last, M=4; 2: first, M=5
  for (genvar g = 0; g < 3; g++) begin : g_mode
    dsr_decim #(.DW(DW), .M(3 + g), .MODE(dsr_pkg::keep_mode_e'(g))) u_dut (
      .clk(clk), .rst_n(rst_n), .in_ce(in_ce), .din(din),
      .out_ce(dst_w[g]), .dout(dout_w[g])
    );
  end

  int checks = 0;
  int fails  = 0;
  int unsigned n_smp;
  logic [DW-1:0] m_hold, m_open;
  logic [DW-1:0] m_out [3];

  function automatic int unsigned m_of(input int i);
    return 3 + i;
  endfunction

  // frame position that produces the strobe: 0 for zero latency, else M-1
  function automatic bit strobe_due(input int i, input int unsigned n);
    return (i == 0) ? (n % m_of(i) == 0) : (n % m_of(i) == m_of(i) - 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    n_smp = 0; m_hold = '0; m_open = '0;
    for (int i = 0; i < 3; i++) m_out[i] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_ce = 1'b0; din = 8'hA5;
    #1;
    for (int i = 0; i < 3; i++) begin
      chk(dout_w[i] == '0, "R7 dout", dout_w[i], '0);
      chk(dst_w[i] == 1'b0, "R7 out_ce", {7'd0, dst_w[i]}, '0);
    end
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic ce, input logic [DW-1:0] d);
    bit due [3];
    @(negedge clk);
    in_ce = ce; din = d;
    #1;
    for (int i = 0; i < 3; i++) begin
      due[i] = ce && strobe_due(i, n_smp);
      chk(dst_w[i] == due[i], ce ? "R1/R2 out_ce" : "R1 out_ce idle",
          {7'd0, dst_w[i]}, {7'd0, due[i]});
    end
    chk(dout_w[0] == (due[0] ? d : m_hold), due[0] ? "R5 zero pass" : "R6 zero hold",
        dout_w[0], due[0] ? d : m_hold);
    if (ce) begin
      if (n_smp % m_of(0) == 0) m_hold = d;
      if (n_smp % m_of(1) == m_of(1) - 1) m_out[1] = d;
      if (n_smp % m_of(2) == m_of(2) - 1) m_out[2] = m_open;
      if (n_smp % m_of(2) == 0) m_open = d;
      n_smp++;
    end
    @(posedge clk);
    #1;
    chk(dout_w[1] == m_out[1], due[1] ? "R3 last take" : "R6 last hold", dout_w[1], m_out[1]);
    chk(dout_w[2] == m_out[2], due[2] ? "R4 first take" : "R6 first hold", dout_w[2], m_out[2]);
  endtask

  initial begin
    #(8 * 50000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_clear();
    do_reset();
    // in_ce every cycle, counting data
    for (int k = 0; k < 40; k++) step(1'b1, DW'(k + 1));
    // corner values at frame edges
    for (int k = 0; k < 20; k++) step(1'b1, (k % 2 == 0) ? 8'hFF : 8'h00);
    // random density
    for (int k = 0; k < 300; k++) step(1'($urandom % 2), DW'($urandom));
    // sparse enables
    for (int k = 0; k < 100; k++) step(1'(($urandom % 5) == 0), DW'($urandom));
    // long idle with toggling data (R6)
    for (int k = 0; k < 30; k++) step(1'b0, DW'($urandom));
    // mid-frame reset (R7), then restart
    step(1'b1, 8'h3C);
    step(1'b1, 8'hC3);
    do_reset();
    for (int k = 0; k < 200; k++) step(1'($urandom % 4 != 0), DW'($urandom));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule